// File: doc/BRIEF.md
# Multi-Level Logic Analyzer Trigger Sequencer

This block watches a probe bus sampled on every clock and decides when a trace capture should fire. It is a programmable state machine with a fixed number of levels, seven by default. Exactly one level is active at a time. The active level compares the probe against a programmed value under a per-bit mask. A mask bit of zero makes that probe bit a don't-care. The comparison can also be qualified by a count of matching samples.

Each level has two programmed actions. When its condition is true, it can raise a store qualifier for the trace memory, step to the next level, or fire the final trigger. When the probe does not match, it can stay where it is, or fall back to a lower level to restart the sequence.

After the trigger fires, the sequencer freezes until software sends an arm strobe. The current level number is always visible at a port, so software can see how far the sequence has progressed. A small write port loads each level's settings.

Top module: `trigseq_top`

## Requirements
- R1: While reset is low and right after it, `level` is 0 and `store_en` and `trigger` are 0. The sequencer starts armed, and every configuration field resets to zero.
- R2: The active level sees a match when `((probe ^ match) & mask) == 0`, so mask bits that are zero are don't-care. Configuration fields are selected by `cfg_field`: 0 for the match value, 1 for the mask, 2 for the count threshold, 3 for the control word.
- R3: A level's condition is true on a matching sample when the number of matching samples counted at that level, including this one, reaches the threshold; thresholds 0 and 1 are true at once. In the default consecutive mode, a mismatch clears the count.
- R4: When control bit 3 is set (cumulative mode), a mismatch that does not cause a jump leaves the count unchanged, so matches need not be back to back.
- R5: Control bits [1:0] select the true action: 1 steps to the next level, 2 fires the trigger, and 0 or 3 stores. A step from the last level fires the trigger instead. The level never rises by more than one per cycle.
- R6: `trigger` is a one-cycle pulse. It appears in the cycle after the clock edge that sampled the deciding probe value, and the same latency applies to `store_en` and `level`.
- R7: After a trigger, the sequencer is done. `level` holds its value, `store_en` and `trigger` stay 0, and the probe has no effect until an arm strobe.
- R8: With control bit 2 set, a mismatch jumps to the level given in control bits [4 +: level width] and clears the count.
- R9: A jump target that is not lower than the current level is treated as remain, so a mismatch can never move the sequence forward.
- R10: An arm strobe has priority over everything else. It returns the sequencer to level 0, clears the count, and re-arms it.
- R11: A true condition with the store action raises `store_en` for that one sample and leaves the level unchanged. In every other cycle `store_en` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| arm | input | 1 | Re-arm strobe |
| probe | input | PROBE_W | Probe bus sampled each clock |
| cfg_we | input | 1 | Configuration write enable |
| cfg_level | input | LVL_W | Level whose field is written |
| cfg_field | input | 2 | Field select (see R2) |
| cfg_wdata | input | CFG_W | Field write data, right aligned |
| store_en | output | 1 | Store qualifier for the trace memory |
| trigger | output | 1 | One-cycle trigger pulse |
| level | output | LVL_W | Index of the active level |

## Verification
The assertions check on every cycle that the level stays in range and never rises by more than one. They also check that the trigger lasts a single cycle and never coincides with a store, that an arm strobe restarts at level 0, and that the done state holds until re-armed. Only the bench scenarios can show the values that depend on the configuration. These are the store response swept over every probe value under two masks, the match counts in consecutive and cumulative modes, back jumps and their illegal-target fallback, a full walk through all seven levels into the trigger, and counts cleared by an arm strobe.

// File: rtl/trigseq_pkg.sv
`timescale 1ns/1ps
package trigseq_pkg;

  typedef enum logic [1:0] {
    ACT_STORE     = 2'd0,
    ACT_ADVANCE   = 2'd1,
    ACT_TRIGGER   = 2'd2,
    ACT_STORE_ALT = 2'd3
  } true_act_e;

  typedef enum logic [1:0] {
    FLD_MATCH  = 2'd0,
    FLD_MASK   = 2'd1,
    FLD_THRESH = 2'd2,
    FLD_CTRL   = 2'd3
  } cfg_field_e;

  localparam int CTRL_FJUMP_BIT = 2;
  localparam int CTRL_CUMUL_BIT = 3;
  localparam int CTRL_TGT_LSB   = 4;

endpackage

// File: rtl/trigseq_cfg_bank.sv
`timescale 1ns/1ps
module trigseq_cfg_bank
  import trigseq_pkg::*;
#(
  parameter int NUM_LEVELS = 7,
  parameter int PROBE_W    = 8,
  parameter int CNT_W      = 8,
  parameter int LVL_W      = 3,
  parameter int CFG_W      = 16,
  parameter int CTRL_W     = CTRL_TGT_LSB + LVL_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               we,
  input  logic [LVL_W-1:0]   wlevel,
  input  logic [1:0]         wfield,
  input  logic [CFG_W-1:0]   wdata,
  input  logic [LVL_W-1:0]   rlevel,
  output logic [PROBE_W-1:0] sel_match,
  output logic [PROBE_W-1:0] sel_mask,
  output logic [CNT_W-1:0]   sel_thr,
  output logic [CTRL_W-1:0]  sel_ctrl
);

  logic [PROBE_W-1:0] match_q [NUM_LEVELS];
  logic [PROBE_W-1:0] mask_q  [NUM_LEVELS];
  logic [CNT_W-1:0]   thr_q   [NUM_LEVELS];
  logic [CTRL_W-1:0]  ctrl_q  [NUM_LEVELS];

  logic [NUM_LEVELS-1:0] lvl_hit;

  // one decoded write strobe per level
  for (genvar g = 0; g < NUM_LEVELS; g++) begin : g_dec
    assign lvl_hit[g] = we && (wlevel == LVL_W'(g));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_LEVELS; i++) begin
        match_q[i] <= '0;
        mask_q[i]  <= '0;
        thr_q[i]   <= '0;
        ctrl_q[i]  <= '0;
      end
    end else begin
      for (int i = 0; i < NUM_LEVELS; i++) begin
        if (lvl_hit[i]) begin
          unique case (cfg_field_e'(wfield))
            FLD_MATCH:  match_q[i] <= wdata[PROBE_W-1:0];
            FLD_MASK:   mask_q[i]  <= wdata[PROBE_W-1:0];
            FLD_THRESH: thr_q[i]   <= wdata[CNT_W-1:0];
            FLD_CTRL:   ctrl_q[i]  <= wdata[CTRL_W-1:0];
            default:    ;
          endcase
        end
      end
    end
  end

  assign sel_match = match_q[rlevel];
  assign sel_mask  = mask_q[rlevel];
  assign sel_thr   = thr_q[rlevel];
  assign sel_ctrl  = ctrl_q[rlevel];

endmodule

// File: rtl/trigseq_match_eval.sv
`timescale 1ns/1ps
module trigseq_match_eval #(
  parameter int PROBE_W = 8,
  parameter int CNT_W   = 8
) (
  input  logic [PROBE_W-1:0] probe,
  input  logic [PROBE_W-1:0] match,
  input  logic [PROBE_W-1:0] mask,
  input  logic [CNT_W-1:0]   cnt,
  input  logic [CNT_W-1:0]   thr,
  output logic               hit,
  output logic               reach
);

  logic [CNT_W:0] cnt_plus;

  assign hit      = ((probe ^ match) & mask) == '0;
  assign cnt_plus = {1'b0, cnt} + {{CNT_W{1'b0}}, 1'b1};
  assign reach    = cnt_plus >= {1'b0, thr};

endmodule

// File: rtl/trigseq_core.sv
`timescale 1ns/1ps
module trigseq_core
  import trigseq_pkg::*;
#(
  parameter int NUM_LEVELS = 7,
  parameter int CNT_W      = 8,
  parameter int LVL_W      = 3,
  parameter int CTRL_W     = CTRL_TGT_LSB + LVL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              arm,
  input  logic              hit,
  input  logic              reach,
  input  logic [CTRL_W-1:0] ctrl,
  output logic [CNT_W-1:0]  cnt,
  output logic [LVL_W-1:0]  level,
  output logic              store_en,
  output logic              trigger
);

  localparam logic [LVL_W-1:0] LAST_LVL = LVL_W'(NUM_LEVELS - 1);

  logic [LVL_W-1:0] lvl_q, lvl_d;
  logic [CNT_W-1:0] cnt_q, cnt_d, cnt_inc;
  logic             armed_q, armed_d;
  logic             store_q, store_d;
  logic             trig_q, trig_d;
  logic             state_en;

  true_act_e        tact;
  logic             fjump, cumul;
  logic [LVL_W-1:0] tgt;

  assign tact  = true_act_e'(ctrl[1:0]);
  assign fjump = ctrl[CTRL_FJUMP_BIT];
  assign cumul = ctrl[CTRL_CUMUL_BIT];
  assign tgt   = ctrl[CTRL_TGT_LSB +: LVL_W];

  assign cnt_inc  = (&cnt_q) ? cnt_q : cnt_q + CNT_W'(1);
  assign state_en = arm | armed_q;

  always_comb begin
    lvl_d   = lvl_q;
    cnt_d   = cnt_q;
    armed_d = armed_q;
    store_d = 1'b0;
    trig_d  = 1'b0;
    if (arm) begin
      lvl_d   = '0;
      cnt_d   = '0;
      armed_d = 1'b1;
    end else if (armed_q) begin
      if (hit && reach) begin
        unique case (tact)
          ACT_ADVANCE: begin
            cnt_d = '0;
            if (lvl_q == LAST_LVL) begin
              trig_d  = 1'b1;
              armed_d = 1'b0;
            end else begin
              lvl_d = lvl_q + LVL_W'(1);
            end
          end
          ACT_TRIGGER: begin
            cnt_d   = '0;
            trig_d  = 1'b1;
            armed_d = 1'b0;
          end
          default: begin
            store_d = 1'b1;
            cnt_d   = cnt_inc;
          end
        endcase
      end else if (hit) begin
        cnt_d = cnt_inc;
      end else if (fjump && (tgt < lvl_q)) begin
        lvl_d = tgt;
        cnt_d = '0;
      end else if (!cumul) begin
        cnt_d = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q   <= '0;
      cnt_q   <= '0;
      armed_q <= 1'b1;
    end else if (state_en) begin
      lvl_q   <= lvl_d;
      cnt_q   <= cnt_d;
      armed_q <= armed_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      store_q <= 1'b0;
      trig_q  <= 1'b0;
    end else begin
      store_q <= store_d;
      trig_q  <= trig_d;
    end
  end

  assign cnt      = cnt_q;
  assign level    = lvl_q;
  assign store_en = store_q;
  assign trigger  = trig_q;

endmodule

// File: rtl/trigseq_top.sv
`timescale 1ns/1ps
module trigseq_top
  import trigseq_pkg::*;
#(
  parameter  int NUM_LEVELS = 7,
  parameter  int PROBE_W    = 8,
  parameter  int CNT_W      = 8,
  parameter  int CFG_W      = 16,
  localparam int LVL_W      = $clog2(NUM_LEVELS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               arm,
  input  logic [PROBE_W-1:0] probe,
  input  logic               cfg_we,
  input  logic [LVL_W-1:0]   cfg_level,
  input  logic [1:0]         cfg_field,
  input  logic [CFG_W-1:0]   cfg_wdata,
  output logic               store_en,
  output logic               trigger,
  output logic [LVL_W-1:0]   level
);

  localparam int CTRL_W = CTRL_TGT_LSB + LVL_W;

  logic [PROBE_W-1:0] sel_match, sel_mask;
  logic [CNT_W-1:0]   sel_thr, cnt;
  logic [CTRL_W-1:0]  sel_ctrl;
  logic               hit, reach;

  trigseq_cfg_bank #(
    .NUM_LEVELS(NUM_LEVELS), .PROBE_W(PROBE_W), .CNT_W(CNT_W),
    .LVL_W(LVL_W), .CFG_W(CFG_W), .CTRL_W(CTRL_W)
  ) cfg_i (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .wlevel(cfg_level),
    .wfield(cfg_field), .wdata(cfg_wdata), .rlevel(level),
    .sel_match(sel_match), .sel_mask(sel_mask),
    .sel_thr(sel_thr), .sel_ctrl(sel_ctrl)
  );

  trigseq_match_eval #(.PROBE_W(PROBE_W), .CNT_W(CNT_W)) eval_i (
    .probe(probe), .match(sel_match), .mask(sel_mask),
    .cnt(cnt), .thr(sel_thr), .hit(hit), .reach(reach)
  );

  trigseq_core #(
    .NUM_LEVELS(NUM_LEVELS), .CNT_W(CNT_W), .LVL_W(LVL_W), .CTRL_W(CTRL_W)
  ) core_i (
    .clk(clk), .rst_n(rst_n), .arm(arm), .hit(hit), .reach(reach),
    .ctrl(sel_ctrl), .cnt(cnt), .level(level),
    .store_en(store_en), .trigger(trigger)
  );

endmodule

// File: rtl/trigseq_checker.sv
`timescale 1ns/1ps
module trigseq_checker #(
  parameter int NUM_LEVELS = 7,
  parameter int LVL_W      = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             arm,
  input logic             store_en,
  input logic             trigger,
  input logic [LVL_W-1:0] level
);

  logic fired_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       fired_q <= 1'b0;
    else if (arm)     fired_q <= 1'b0;
    else if (trigger) fired_q <= 1'b1;
  end

  assert_level_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
    level < LVL_W'(NUM_LEVELS));

  assert_single_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (level <= $past(level)) || (level == $past(level) + LVL_W'(1)));

  assert_trig_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    trigger |=> !trigger);

  assert_done_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (fired_q && !arm) |=> ($stable(level) && !trigger && !store_en));

  assert_arm_restart_R10: assert property (@(posedge clk) disable iff (!rst_n)
    arm |=> (level == '0 && !trigger && !store_en));

  assert_store_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(store_en && trigger));

endmodule

bind trigseq_top trigseq_checker #(.NUM_LEVELS(NUM_LEVELS), .LVL_W(LVL_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .arm(arm), .store_en(store_en),
  .trigger(trigger), .level(level)
);

// File: tb/trigseq_top_tb_top.sv
`timescale 1ns/1ps
module trigseq_top_tb_top;
  localparam int NL = 7;
  localparam int PW = 8;
  localparam int CW = 8;
  localparam int DW = 16;
  localparam int LW = $clog2(NL);

  logic          clk = 1'b0;
  logic          rst_n, arm, cfg_we;
  logic [PW-1:0] probe;
  logic [LW-1:0] cfg_level;
  logic [1:0]    cfg_field;
  logic [DW-1:0] cfg_wdata;
  logic          store_en, trigger;
  logic [LW-1:0] level;

  int n_chk = 0;
  int n_err = 0;

  always #2.5 clk = ~clk;

  trigseq_top #(.NUM_LEVELS(NL), .PROBE_W(PW), .CNT_W(CW), .CFG_W(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .arm(arm), .probe(probe), .cfg_we(cfg_we),
    .cfg_level(cfg_level), .cfg_field(cfg_field), .cfg_wdata(cfg_wdata),
    .store_en(store_en), .trigger(trigger), .level(level)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input int lvl, input int fld, input int data);
    cfg_level = LW'(lvl);
    cfg_field = 2'(fld);
    cfg_wdata = DW'(data);
    cfg_we    = 1'b1;
    tick();
    cfg_we    = 1'b0;
  endtask

  task automatic clear_cfg();
    for (int l = 0; l < NL; l++)
      for (int f = 0; f < 4; f++) wr(l, f, 0);
  endtask

  task automatic do_arm();
    arm = 1'b1;
    tick();
    arm = 1'b0;
  endtask

  task automatic step(input int p);
    probe = PW'(p);
    tick();
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog R7 actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; arm = 1'b0; cfg_we = 1'b0; probe = '0;
    cfg_level = '0; cfg_field = '0; cfg_wdata = '0;
    tick(); tick();
    check("R1 reset level", int'(level), 0);
    check("R1 reset store_en", int'(store_en), 0);
    check("R1 reset trigger", int'(trigger), 0);
    rst_n = 1'b1;
    tick();
    check("R1 level after reset", int'(level), 0);
    check("R1 trigger after reset", int'(trigger), 0);

    // R2 / R11: sweep all probe values, store action, two masks
    wr(0, 0, 'hA5); wr(0, 1, 'hF0); wr(0, 3, 0);
    do_arm();
    for (int p = 0; p < 256; p++) begin
      step(p);
      check("R2 store sweep A", int'(store_en), (((p ^ 'hA5) & 'hF0) == 0) ? 1 : 0);
      check("R11 level held on store", int'(level), 0);
    end
    wr(0, 0, 'h18); wr(0, 1, 'h3C); wr(0, 3, 3);
    do_arm();
    for (int p = 0; p < 256; p++) begin
      step(p);
      check("R2 store sweep B", int'(store_en), (((p ^ 'h18) & 'h3C) == 0) ? 1 : 0);
    end

    // R11: store with threshold 2 only from second match
    wr(0, 0, 'h3C); wr(0, 1, 'hFF); wr(0, 2, 2); wr(0, 3, 0);
    do_arm();
    step('h3C); check("R11 store below threshold", int'(store_en), 0);
    step('h3C); check("R11 store at threshold", int'(store_en), 1);
    step('h00); check("R11 store off on mismatch", int'(store_en), 0);

    // R3: consecutive count threshold 3, advance
    clear_cfg();
    wr(0, 0, 'h3C); wr(0, 1, 'hFF); wr(0, 2, 3); wr(0, 3, 1);
    wr(1, 0, 'hFF); wr(1, 1, 'hFF);
    do_arm();
    step('h3C); step('h3C); step('h00);
    check("R3 level after broken run", int'(level), 0);
    step('h3C); step('h3C);
    check("R3 level before third match", int'(level), 0);
    step('h3C);
    check("R3 level after third match", int'(level), 1);

    // R4: cumulative count
    wr(0, 3, 1 | 8);
    do_arm();
    step('h3C); step('h00); step('h3C);
    check("R4 level after two matches", int'(level), 0);
    step('h3C);
    check("R4 cumulative advance", int'(level), 1);

    // R10: arm clears the partial count
    wr(0, 3, 1);
    do_arm();
    step('h3C); step('h3C);
    do_arm();
    check("R10 arm returns level 0", int'(level), 0);
    step('h3C); step('h3C);
    check("R10 count restarted", int'(level), 0);
    step('h3C);
    check("R10 advance after full count", int'(level), 1);

    // R5 / R6 / R7: walk through all levels, last step fires trigger
    clear_cfg();
    for (int l = 0; l < NL; l++) wr(l, 3, 1);
    do_arm();
    for (int k = 1; k < NL; k++) begin
      step(0);
      check("R5 advance walk", int'(level), k);
      check("R6 no early trigger", int'(trigger), 0);
    end
    step(0);
    check("R5 last advance fires trigger", int'(trigger), 1);
    check("R7 level at trigger", int'(level), NL - 1);
    step(0);
    check("R6 trigger one cycle", int'(trigger), 0);
    for (int k = 0; k < 5; k++) begin
      step(k * 37);
      check("R7 done level", int'(level), NL - 1);
      check("R7 done trigger", int'(trigger), 0);
      check("R7 done store", int'(store_en), 0);
    end
    do_arm();
    check("R10 re-arm level", int'(level), 0);
    step(0);
    check("R10 restart advances", int'(level), 1);

    // R5 trigger action directly at level 0
    clear_cfg();
    wr(0, 3, 2);
    do_arm();
    step(0);
    check("R5 trigger action", int'(trigger), 1);
    check("R5 trigger action level", int'(level), 0);
    step(0);
    check("R6 trigger action pulse", int'(trigger), 0);

    // R8: back jump to level 0
    clear_cfg();
    wr(0, 3, 1); wr(1, 3, 1);
    wr(2, 0, 'h55); wr(2, 1, 'hFF); wr(2, 3, 1 | 4 | (0 << 4));
    do_arm();
    step(0); step(0);
    check("R8 reached level 2", int'(level), 2);
    step('h00);
    check("R8 back jump", int'(level), 0);

    // R9: target equal to or above current level is remain
    wr(2, 3, 1 | 4 | (2 << 4));
    do_arm();
    step(0); step(0); step('h00);
    check("R9 equal target remains", int'(level), 2);
    wr(2, 3, 1 | 4 | (5 << 4));
    step('h00);
    check("R9 higher target remains", int'(level), 2);
    step('h55);
    check("R9 match still advances", int'(level), 3);

    finish_run();
  end
endmodule